// File: doc/BRIEF.md
# Interrupt-Vector Capability Registers and BAR Layout

This block holds the configuration-space registers of an extended message-signalled interrupt capability. It also works out where the vector table and the pending-bit array sit inside one of the device's memory BARs. Three strap inputs describe the device: the number of vectors, the index of the BAR that carries the table, and the size that BAR would have without the capability. The straps are captured while reset is held.

The block grows the BAR so that both interrupt structures sit directly above the original contents. From that it derives the grown BAR size and the two offset registers that software reads to find the structures.

Configuration software reaches the 12-byte capability through a dword-wide port with byte enables. Only two bits can be written: the enable bit and the function-mask bit. A write that reaches those bits can pulse two outputs:
- a rescan request, which tells the vector table to deliver any pending interrupts that are now unmasked;
- a pulse that clears the legacy INTx line.

If the straps describe a device that cannot be built, the block raises an error flag and the capability reads as absent.

Top module: `msicap_top`

## Requirements
- R1: After a synchronous reset (rst_n low at a rising edge), the enable and function-mask bits read 0 and neither pulse output is high.
- R2: Reading dword 0 returns the following fields:
  - bits 7:0 are the capability ID 0x11;
  - bits 15:8 are 0;
  - bits 26:16 are the vector count minus one;
  - bits 29:27 are 0;
  - bit 30 is the function mask;
  - bit 31 is the enable bit.
- R3: A strapped vector count of 0, or of more than 2048, raises cfg_err_o and clears cap_present_o.
- R4: A strapped BAR size greater than 0x80000000 raises cfg_err_o. A size of exactly 0x80000000 is accepted and grows to 0x100000000.
- R5: The grown BAR size follows these rules, for an original size that is zero or a power of two:
  - an original size of 0 gives 0x1000;
  - a nonzero size below 0x1000 gives 0x2000;
  - any larger size is doubled.
- R6: The table-offset register, which is dword 1 and also tbl_off_o, is the original size rounded up to at least 0x1000 (0 stays 0), OR'd with the BAR index in bits 2:0.
- R7: The pending-array register, which is dword 2 and also pba_off_o, is that rounded size plus 0x800, OR'd with the BAR index.
- R8: Writes change only bit 31 (enable) and bit 30 (function mask) of dword 0, and only when byte enable 3 is set. All other bytes, bits and dwords keep their read values.
- R9: A write that sets byte enable 3 of dword 0 with enable=1 and mask=0 produces rescan_o high for the one cycle after the write edge.
- R10: A write that sets byte enable 3 of dword 0 with enable=1 produces intx_clr_o high for the one cycle after the write edge, whatever the mask value. A write without byte enable 3 produces no pulse.
- R11: While cfg_err_o is high:
  - every read returns 0;
  - writes are ignored;
  - bar_size_o, tbl_off_o and pba_off_o are 0.
- R12: vec_en_o and fn_mask_o always equal the enable and function-mask bits that software reads back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; straps are sampled while it is low |
| strap_vec_count | input | 12 | Number of vectors |
| strap_bar_idx | input | 3 | Index of the BAR holding the table |
| strap_bar_size | input | 32 | Original BAR size (zero or a power of two) |
| cfg_wr | input | 1 | Write strobe for the configuration port |
| cfg_dw | input | 2 | Dword index inside the capability |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for cfg_dw (combinational) |
| bar_size_o | output | 33 | Grown BAR size |
| tbl_off_o | output | 32 | Table-offset register value |
| pba_off_o | output | 32 | Pending-array offset register value |
| vec_en_o | output | 1 | Capability enable bit |
| fn_mask_o | output | 1 | Function-mask bit |
| cap_present_o | output | 1 | Capability configured successfully |
| cfg_err_o | output | 1 | Strap configuration rejected |
| rescan_o | output | 1 | One-cycle rescan request to the vector table |
| intx_clr_o | output | 1 | One-cycle legacy INTx clear |

## Verification
The straps are drawn from five kinds of value:
- a zero size, which separates the "no BAR" case from rounding;
- sizes below one page, which exercise rounding up;
- page-sized and larger sizes, which exercise plain doubling;
- sizes just above the 2 GiB limit, which must be refused;
- vector counts at 0, 1, 2048 and 2049.

Each kind drives a different branch of the growth and error logic. Random writes with mixed byte enables and control values separate three outcomes:
- a write that misses byte 3, which changes nothing;
- a write that enables with the mask set, which clears INTx only;
- a write that enables with the mask clear, which also requests a rescan.

// File: rtl/msicap_pkg.sv
package msicap_pkg;
   localparam int          QSIZE_W   = 11;
   localparam int          CNT_W     = QSIZE_W + 1;
   localparam int          MAX_VEC   = 1 << QSIZE_W;
   localparam logic [7:0]  CAP_ID    = 8'h11;
   localparam int          CAP_DWORDS = 3;
   localparam int          CTRL_LANE = 3;
   localparam int          EN_POS    = 7;
   localparam int          MASK_POS  = 6;

   typedef struct packed {
      logic en;
      logic mask;
   } ctrl_t;

   typedef struct packed {
      logic bad_count;
      logic bad_space;
   } fault_t;
endpackage

// File: rtl/msicap_layout.sv
module msicap_layout
   import msicap_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int PAGE_BYTES = 4096,
   parameter int BIR_W      = 3
) (
   input  logic [CNT_W-1:0]  vec_count,
   input  logic [BIR_W-1:0]  bar_idx,
   input  logic [ADDR_W-1:0] orig_size,
   output logic [ADDR_W:0]   grown_size,
   output logic [ADDR_W-1:0] tbl_reg,
   output logic [ADDR_W-1:0] pba_reg,
   output fault_t            fault
);
   localparam logic [ADDR_W:0]   PAGE_W  = (ADDR_W+1)'(PAGE_BYTES);
   localparam logic [ADDR_W-1:0] PAGE_N  = ADDR_W'(PAGE_BYTES);
   localparam logic [ADDR_W-1:0] HALF_PG = ADDR_W'(PAGE_BYTES / 2);
   localparam logic [ADDR_W-1:0] LIMIT   = {1'b1, {(ADDR_W-1){1'b0}}};
   localparam logic [CNT_W-1:0]  MAXC    = CNT_W'(MAX_VEC);

   if ((PAGE_BYTES & (PAGE_BYTES - 1)) != 0) begin : g_bad_page
      $error("PAGE_BYTES must be a power of two");
   end
   if ((1 << BIR_W) > PAGE_BYTES / 2) begin : g_bad_bir
      $error("BIR_W too wide for page alignment");
   end
   if (ADDR_W < 16) begin : g_bad_addr
      $error("ADDR_W too small");
   end

   logic                  is_zero;
   logic                  is_small;
   logic [ADDR_W-1:0]     rounded;
   logic [ADDR_W-1:0]     idx_ext;

   assign is_zero  = (orig_size == '0);
   assign is_small = !is_zero && (orig_size < PAGE_N);
   assign idx_ext  = ADDR_W'(bar_idx);

   always_comb begin
      if (is_zero) begin
         rounded    = '0;
         grown_size = PAGE_W;
      end else if (is_small) begin
         rounded    = PAGE_N;
         grown_size = PAGE_W << 1;
      end else begin
         rounded    = orig_size;
         grown_size = {orig_size, 1'b0};
      end
   end

   assign tbl_reg = rounded | idx_ext;
   assign pba_reg = (rounded + HALF_PG) | idx_ext;

   assign fault.bad_count = (vec_count == '0) || (vec_count > MAXC);
   assign fault.bad_space = (orig_size > LIMIT);
endmodule

// File: rtl/msicap_rescan.sv
module msicap_rescan
   import msicap_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  ctrl_hit,
   input  ctrl_t ctrl_next,
   output logic  rescan,
   output logic  intx_clr
);
   logic rescan_q;
   logic intx_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rescan_q <= 1'b0;
         intx_q   <= 1'b0;
      end else begin
         intx_q   <= ctrl_hit && ctrl_next.en;
         rescan_q <= ctrl_hit && ctrl_next.en && !ctrl_next.mask;
      end
   end

   assign rescan   = rescan_q;
   assign intx_clr = intx_q;
endmodule

// File: rtl/msicap_cfgport.sv
module msicap_cfgport
   import msicap_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_ok,
   input  logic [CNT_W-1:0]  vec_count,
   input  logic [ADDR_W-1:0] tbl_reg,
   input  logic [ADDR_W-1:0] pba_reg,
   input  logic              cfg_wr,
   input  logic [1:0]        cfg_dw,
   input  logic [3:0]        cfg_be,
   input  logic [31:0]       cfg_wdata,
   output logic [31:0]       cfg_rdata,
   output ctrl_t             ctrl,
   output logic              ctrl_hit,
   output ctrl_t             ctrl_next
);
   if (ADDR_W > 32) begin : g_bad_w
      $error("offset registers are one dword");
   end

   ctrl_t             ctrl_q;
   logic [QSIZE_W-1:0] qsize;
   logic [31:0]       dword [CAP_DWORDS];
   logic [3:0][7:0]   lane_rd;
   logic [31:0]       sel;

   assign qsize = QSIZE_W'(vec_count - CNT_W'(1));

   assign ctrl_hit = cfg_wr && cap_ok && (cfg_dw == 2'd0) && cfg_be[CTRL_LANE];
   assign ctrl_next.en   = cfg_wdata[8*CTRL_LANE + EN_POS];
   assign ctrl_next.mask = cfg_wdata[8*CTRL_LANE + MASK_POS];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (ctrl_hit) begin
         ctrl_q <= ctrl_next;
      end
   end

   assign dword[0] = {ctrl_q.en, ctrl_q.mask, {(16-QSIZE_W-2){1'b0}}, qsize, 8'h00, CAP_ID};
   assign dword[1] = 32'(tbl_reg);
   assign dword[2] = 32'(pba_reg);

   always_comb begin
      sel = '0;
      for (int i = 0; i < CAP_DWORDS; i++) begin
         if (cfg_dw == 2'(i)) sel = dword[i];
      end
   end

   for (genvar b = 0; b < 4; b++) begin : g_lane
      assign lane_rd[b] = cap_ok ? sel[8*b +: 8] : 8'h00;
   end

   assign cfg_rdata = lane_rd;
   assign ctrl      = ctrl_q;
endmodule

// File: rtl/msicap_top.sv
module msicap_top
   import msicap_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int PAGE_BYTES = 4096,
   parameter int BIR_W      = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  strap_vec_count,
   input  logic [BIR_W-1:0]  strap_bar_idx,
   input  logic [ADDR_W-1:0] strap_bar_size,
   input  logic              cfg_wr,
   input  logic [1:0]        cfg_dw,
   input  logic [3:0]        cfg_be,
   input  logic [31:0]       cfg_wdata,
   output logic [31:0]       cfg_rdata,
   output logic [ADDR_W:0]   bar_size_o,
   output logic [ADDR_W-1:0] tbl_off_o,
   output logic [ADDR_W-1:0] pba_off_o,
   output logic              vec_en_o,
   output logic              fn_mask_o,
   output logic              cap_present_o,
   output logic              cfg_err_o,
   output logic              rescan_o,
   output logic              intx_clr_o
);
   logic [CNT_W-1:0]  cnt_q;
   logic [BIR_W-1:0]  idx_q;
   logic [ADDR_W-1:0] size_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= strap_vec_count;
         idx_q  <= strap_bar_idx;
         size_q <= strap_bar_size;
      end
   end

   logic [ADDR_W:0]   grown;
   logic [ADDR_W-1:0] tbl_reg;
   logic [ADDR_W-1:0] pba_reg;
   fault_t            fault;
   logic              cap_ok;

   msicap_layout #(
      .ADDR_W    (ADDR_W),
      .PAGE_BYTES(PAGE_BYTES),
      .BIR_W     (BIR_W)
   ) u_layout (
      .vec_count (cnt_q),
      .bar_idx   (idx_q),
      .orig_size (size_q),
      .grown_size(grown),
      .tbl_reg   (tbl_reg),
      .pba_reg   (pba_reg),
      .fault     (fault)
   );

   assign cap_ok = !(fault.bad_count || fault.bad_space);

   ctrl_t ctrl;
   ctrl_t ctrl_next;
   logic  ctrl_hit;

   msicap_cfgport #(.ADDR_W(ADDR_W)) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .cap_ok   (cap_ok),
      .vec_count(cnt_q),
      .tbl_reg  (tbl_reg),
      .pba_reg  (pba_reg),
      .cfg_wr   (cfg_wr),
      .cfg_dw   (cfg_dw),
      .cfg_be   (cfg_be),
      .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata),
      .ctrl     (ctrl),
      .ctrl_hit (ctrl_hit),
      .ctrl_next(ctrl_next)
   );

   msicap_rescan u_rescan (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctrl_hit (ctrl_hit),
      .ctrl_next(ctrl_next),
      .rescan   (rescan_o),
      .intx_clr (intx_clr_o)
   );

   assign bar_size_o    = cap_ok ? grown   : '0;
   assign tbl_off_o     = cap_ok ? tbl_reg : '0;
   assign pba_off_o     = cap_ok ? pba_reg : '0;
   assign vec_en_o      = ctrl.en;
   assign fn_mask_o     = ctrl.mask;
   assign cap_present_o = cap_ok;
   assign cfg_err_o     = !cap_ok;
endmodule

// File: rtl/msicap_checker.sv
module msicap_checker #(
   parameter int ADDR_W     = 32,
   parameter int PAGE_BYTES = 4096
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_wr,
   input logic [ADDR_W:0]   bar_size_o,
   input logic [ADDR_W-1:0] tbl_off_o,
   input logic              vec_en_o,
   input logic              fn_mask_o,
   input logic              cap_present_o,
   input logic              cfg_err_o,
   input logic              rescan_o,
   input logic              intx_clr_o
);
   localparam logic [ADDR_W:0] PG = (ADDR_W+1)'(PAGE_BYTES);

   AST_RESET_CLEARS: assert property (@(posedge clk)
      !rst_n |=> (!vec_en_o && !fn_mask_o && !rescan_o && !intx_clr_o)); // R1

   AST_RESCAN_STATE: assert property (@(posedge clk) disable iff (!rst_n)
      rescan_o |-> (vec_en_o && !fn_mask_o)); // R9

   AST_RESCAN_CLEARS_INTX: assert property (@(posedge clk) disable iff (!rst_n)
      rescan_o |-> intx_clr_o); // R10

   AST_ABSENT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err_o |-> (!cap_present_o && !vec_en_o && !fn_mask_o && !rescan_o)); // R11

   AST_CTRL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(cfg_wr) |-> ($stable(vec_en_o) && $stable(fn_mask_o))); // R8

   AST_TABLE_INSIDE_BAR: assert property (@(posedge clk) disable iff (!rst_n)
      cap_present_o |->
         (({1'b0, tbl_off_o} & ~(PG - 1'b1)) + PG <= bar_size_o)); // R5
endmodule

bind msicap_top msicap_checker #(
   .ADDR_W    (ADDR_W),
   .PAGE_BYTES(PAGE_BYTES)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cfg_wr       (cfg_wr),
   .bar_size_o   (bar_size_o),
   .tbl_off_o    (tbl_off_o),
   .vec_en_o     (vec_en_o),
   .fn_mask_o    (fn_mask_o),
   .cap_present_o(cap_present_o),
   .cfg_err_o    (cfg_err_o),
   .rescan_o     (rescan_o),
   .intx_clr_o   (intx_clr_o)
);

// File: tb/msicap_top_test.sv
module msicap_top_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] strap_vec_count = 12'd1;
   logic [2:0]  strap_bar_idx = 3'd0;
   logic [31:0] strap_bar_size = 32'd0;
   logic        cfg_wr = 1'b0;
   logic [1:0]  cfg_dw = 2'd0;
   logic [3:0]  cfg_be = 4'd0;
   logic [31:0] cfg_wdata = 32'd0;
   logic [31:0] cfg_rdata;
   logic [32:0] bar_size_o;
   logic [31:0] tbl_off_o;
   logic [31:0] pba_off_o;
   logic        vec_en_o, fn_mask_o, cap_present_o, cfg_err_o, rescan_o, intx_clr_o;

   always #(CLK_PERIOD/2) clk = ~clk;

   msicap_top uut (.*);

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   bit m_en, m_mask;

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   function automatic bit f_err(logic [11:0] c, logic [31:0] s);
      return (c == 0) || (c > 12'd2048) || (s > 32'h8000_0000);
   endfunction
   function automatic logic [31:0] f_round(logic [31:0] s);
      if (s == 0) return 32'd0;
      if (s < 32'h1000) return 32'h1000;
      return s;
   endfunction
   function automatic logic [32:0] f_grow(logic [31:0] s);
      if (s == 0) return 33'h1000;
      if (s < 32'h1000) return 33'h2000;
      return {s, 1'b0};
   endfunction
   function automatic logic [31:0] f_dw0(logic [11:0] c, bit e, bit m);
      logic [10:0] q = 11'(c - 12'd1);
      return {e, m, 3'b000, q, 8'h00, 8'h11};
   endfunction

   task automatic do_reset(logic [11:0] c, logic [2:0] i, logic [31:0] s);
      @(negedge clk);
      strap_vec_count = c; strap_bar_idx = i; strap_bar_size = s;
      rst_n = 1'b0;
      @(posedge clk); @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      m_en = 0; m_mask = 0;
   endtask

   task automatic rd(logic [1:0] dw, output logic [31:0] d);
      cfg_dw = dw;
      #1;
      d = cfg_rdata;
   endtask

   task automatic check_layout();
      bit e = f_err(strap_vec_count, strap_bar_size);
      logic [31:0] r = f_round(strap_bar_size);
      logic [31:0] d;
      chk(e ? "R3/R4 err" : "R3/R4 ok", 64'(cfg_err_o), 64'(e));
      chk("R3 present", 64'(cap_present_o), 64'(!e));
      chk("R5 grow", 64'(bar_size_o), e ? 64'd0 : 64'(f_grow(strap_bar_size)));
      chk("R6 tbl", 64'(tbl_off_o), e ? 64'd0 : 64'(r | 32'(strap_bar_idx)));
      chk("R7 pba", 64'(pba_off_o), e ? 64'd0 : 64'((r + 32'h800) | 32'(strap_bar_idx)));
      rd(2'd0, d); chk("R2 dw0", 64'(d), e ? 64'd0 : 64'(f_dw0(strap_vec_count, m_en, m_mask)));
      rd(2'd1, d); chk("R6 dw1", 64'(d), e ? 64'd0 : 64'(r | 32'(strap_bar_idx)));
      rd(2'd2, d); chk("R7 dw2", 64'(d), e ? 64'd0 : 64'((r + 32'h800) | 32'(strap_bar_idx)));
      rd(2'd3, d); chk("R11 dw3", 64'(d), 64'd0);
   endtask

   task automatic wr(logic [1:0] dw, logic [3:0] be, logic [31:0] data);
      bit e = f_err(strap_vec_count, strap_bar_size);
      bit hit = !e && dw == 0 && be[3];
      logic [31:0] d;
      @(negedge clk);
      cfg_wr = 1; cfg_dw = dw; cfg_be = be; cfg_wdata = data;
      @(posedge clk);
      @(negedge clk);
      cfg_wr = 0;
      if (hit) begin m_en = data[31]; m_mask = data[30]; end
      chk("R9 rescan", 64'(rescan_o), 64'(hit && data[31] && !data[30]));
      chk("R10 intx", 64'(intx_clr_o), 64'(hit && data[31]));
      chk("R12 en", 64'(vec_en_o), 64'(m_en));
      chk("R12 mask", 64'(fn_mask_o), 64'(m_mask));
      rd(2'd0, d);
      chk("R8 dw0 after write", 64'(d), e ? 64'd0 : 64'(f_dw0(strap_vec_count, m_en, m_mask)));
      @(negedge clk);
      chk("R9 single cycle", 64'(rescan_o), 64'd0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin : main
      logic [11:0] c;
      logic [31:0] s;
      void'($urandom(32'd4242));

      // R1 reset state, then directed corners
      do_reset(12'd8, 3'd2, 32'h0);
      chk("R1 en", 64'(vec_en_o), 64'd0);
      chk("R1 mask", 64'(fn_mask_o), 64'd0);
      chk("R1 rescan", 64'(rescan_o), 64'd0);
      chk("R1 intx", 64'(intx_clr_o), 64'd0);
      check_layout();
      wr(2'd0, 4'b0111, 32'hFFFF_FFFF);   // R8 byte 3 not covered, R10 no pulse
      wr(2'd0, 4'b1000, 32'hC000_0000);   // R10 intx only when masked
      wr(2'd0, 4'b1000, 32'h8000_0000);   // R9 rescan
      wr(2'd1, 4'b1111, 32'h0);           // R8 read-only dword
      do_reset(12'd8, 3'd2, 32'h0);       // R1 after enabled state
      chk("R1 en after use", 64'(vec_en_o), 64'd0);

      do_reset(12'd1, 3'd5, 32'h0000_0100);    check_layout();   // R5 small
      do_reset(12'd2048, 3'd1, 32'h0001_0000); check_layout();   // R3 max count
      do_reset(12'd2049, 3'd1, 32'h0001_0000); check_layout();   // R3 too many
      do_reset(12'd0, 3'd1, 32'h0001_0000);    check_layout();   // R3 zero
      wr(2'd0, 4'b1111, 32'h8000_0000);                          // R11 ignored
      do_reset(12'd4, 3'd0, 32'h8000_0000);    check_layout();   // R4 limit
      do_reset(12'd4, 3'd0, 32'h8000_0001);    check_layout();   // R4 over

      for (int it = 0; it < 40; it++) begin
         case ($urandom % 5)
            0: s = 32'h0;
            1: s = 32'h1 << (3 + $urandom % 9);
            2: s = 32'h1 << (12 + $urandom % 20);
            3: s = 32'h8000_0001 + ($urandom % 32'h1000);
            default: s = 32'h1 << (3 + $urandom % 29);
         endcase
         case ($urandom % 6)
            0: c = 12'd0;
            1: c = 12'd2049 + 12'($urandom % 100);
            default: c = 12'd1 + 12'($urandom % 2048);
         endcase
         do_reset(c, 3'($urandom % 6), s);
         check_layout();
         for (int w = 0; w < 5; w++) begin
            wr(2'($urandom % 4), 4'($urandom), $urandom);
         end
         check_layout();
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule